// File: doc/BRIEF.md
# Base-and-Limit Address Relocation Unit

This block sits beside the execute stage of a small processor and turns logical data addresses into 24-bit physical addresses. While the memory-management enable bit of the status word is set, every address is shifted by a low-bound register. The shifted result is then compared with a high-bound register. An address that lands above the high bound, or that runs past the top of the 24-bit space, is refused with an abort strobe. While the enable bit is clear, addresses pass through unchanged.

A second request channel gives the supervisor access to the two bound registers. It offers a read, a write and a validate query. The validate query compares an untranslated physical address with both bounds and reports a would-be violation on an overflow-flag output. Any request on this channel made in user mode is refused with a privilege-trap strobe and has no other effect.

Both channels answer exactly one cycle after the request, with registered outputs. The caller uses the abort and privilege strobes to start its own trap handling.

Top module: `addr_reloc_unit`

## Requirements
- R1: After reset the low bound reads 0x000000, the high bound reads 0xFFFFFF, and every response output is 0.
- R2: A translate request with status bit 13 set gives, one cycle later, `xlat_rsp_valid`=1 and `xlat_paddr` = `xlat_laddr` + low bound, when that sum fits in 24 bits and is not above the high bound. A cycle with no translate request gives `xlat_rsp_valid`=0 in the next cycle.
- R3: With status bit 13 set, a translate whose sum carries out of 24 bits, or whose sum is above the high bound, gives `xlat_abort`=1 and `xlat_paddr`=0. A sum equal to the high bound is allowed.
- R4: With status bit 13 clear, a translate gives `xlat_paddr` = `xlat_laddr` and `xlat_abort`=0, whatever the bounds hold.
- R5: A control request while status bit 15 is 0 (user mode) gives `ctl_priv_trap`=1 with `ctl_rdata`=0 and `ctl_ovf`=0, and changes neither bound register.
- R6: In supervisor mode (bit 15 = 1), op 0 reads and op 1 writes the bound chosen by `ctl_sel` (0 = low, 1 = high). Read data appears one cycle later. A write is seen by requests issued from the next cycle on.
- R7: Op 2 (validate) sets `ctl_ovf`=1 one cycle later exactly when `ctl_wdata` is below the low bound or above the high bound, whatever the value of bit 13.
- R8: A translate issued in the same cycle as a bound write uses the bound values from before that write.
- R9: Op 3 in supervisor mode is acknowledged with `ctl_rsp_valid`=1, and with `ctl_rdata`, `ctl_ovf` and `ctl_priv_trap` all 0. It changes no state.
- R10: `xlat_abort` is only ever raised together with `xlat_rsp_valid`, and `ctl_priv_trap` only together with `ctl_rsp_valid`. Each request therefore raises at most one trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_word | input | 16 | Processor status; bit 15 supervisor, bit 13 translation enable |
| xlat_req | input | 1 | Translate request strobe |
| xlat_laddr | input | 24 | Logical address to translate |
| xlat_rsp_valid | output | 1 | Translate response valid |
| xlat_paddr | output | 24 | Physical address (0 on abort) |
| xlat_abort | output | 1 | Bound violation strobe |
| ctl_req | input | 1 | Control request strobe |
| ctl_op | input | 2 | 0 read, 1 write, 2 validate, 3 reserved |
| ctl_sel | input | 1 | Bound select: 0 low, 1 high |
| ctl_wdata | input | 24 | Write data, or the address for validate |
| ctl_rsp_valid | output | 1 | Control response valid |
| ctl_rdata | output | 24 | Read data |
| ctl_priv_trap | output | 1 | User-mode access strobe |
| ctl_ovf | output | 1 | Validate result: would violate |

## Verification
A translate can land in the same cycle as a supervisor write to the bound it depends on. The expected result is then taken from the bounds as they stood before the write, and the next translate must see the new value. The bench provokes this with a directed pair: it lowers the high bound while translating an address that falls between the old and the new limit, then translates the same address again. The random phase also overlaps the two channels freely. A bench model, which applies writes only after it has predicted the responses of the same cycle, decides every outcome.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    localparam int unsigned PA_W = 24;

    typedef logic [PA_W-1:0] paddr_t;

    typedef enum logic [1:0] {
        CTL_READ  = 2'd0,
        CTL_WRITE = 2'd1,
        CTL_CHECK = 2'd2,
        CTL_RSVD  = 2'd3
    } ctl_op_e;

    typedef struct packed {
        logic   valid;
        logic   abort;
        paddr_t addr;
    } xlat_rsp_t;

    typedef struct packed {
        logic   valid;
        logic   priv;
        logic   ovf;
        paddr_t data;
    } ctl_rsp_t;

    typedef struct packed {
        xlat_rsp_t x;
        ctl_rsp_t  c;
    } rsp_state_t;

    typedef struct packed {
        paddr_t lo;
        paddr_t hi;
    } bound_state_t;
endpackage

// File: rtl/reloc_bounds.sv
module reloc_bounds
    import reloc_pkg::*;
#(
    parameter paddr_t LO_RST = '0,
    parameter paddr_t HI_RST = '1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   wr_sel,
    input  paddr_t wr_data,
    output paddr_t lo_q,
    output paddr_t hi_q
);
    bound_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel) st_d.hi = wr_data;
            else        st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lo <= LO_RST;
            st_q.hi <= HI_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_q = st_q.lo;
    assign hi_q = st_q.hi;
endmodule

// File: rtl/reloc_xlat.sv
module reloc_xlat
    import reloc_pkg::*;
(
    input  logic   en,
    input  paddr_t laddr,
    input  paddr_t lo,
    input  paddr_t hi,
    output paddr_t paddr,
    output logic   abort
);
    logic [PA_W:0] sum;

    always_comb begin
        sum = {1'b0, laddr} + {1'b0, lo};
        if (!en) begin
            paddr = laddr;
            abort = 1'b0;
        end else begin
            abort = sum[PA_W] | (sum[PA_W-1:0] > hi);
            paddr = abort ? '0 : sum[PA_W-1:0];
        end
    end
endmodule

// File: rtl/reloc_window_chk.sv
module reloc_window_chk
    import reloc_pkg::*;
(
    input  paddr_t addr,
    input  paddr_t lo,
    input  paddr_t hi,
    output logic   outside
);
    assign outside = (addr < lo) | (addr > hi);
endmodule

// File: rtl/addr_reloc_unit.sv
module addr_reloc_unit
    import reloc_pkg::*;
#(
    parameter int unsigned STATUS_W   = 16,
    parameter int unsigned MMU_EN_BIT = 13,
    parameter int unsigned SUPV_BIT   = 15,
    parameter paddr_t      LO_RST     = '0,
    parameter paddr_t      HI_RST     = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_word,
    input  logic                xlat_req,
    input  logic [PA_W-1:0]     xlat_laddr,
    output logic                xlat_rsp_valid,
    output logic [PA_W-1:0]     xlat_paddr,
    output logic                xlat_abort,
    input  logic                ctl_req,
    input  logic [1:0]          ctl_op,
    input  logic                ctl_sel,
    input  logic [PA_W-1:0]     ctl_wdata,
    output logic                ctl_rsp_valid,
    output logic [PA_W-1:0]     ctl_rdata,
    output logic                ctl_priv_trap,
    output logic                ctl_ovf
);
    logic    supv, mm_en, wr_en, outside, x_abort;
    paddr_t  lo, hi, x_paddr;
    ctl_op_e op;
    logic    unused_status;

    rsp_state_t rsp_d, rsp_q;

    assign supv          = status_word[SUPV_BIT];
    assign mm_en         = status_word[MMU_EN_BIT];
    assign unused_status = ^status_word;
    assign op            = ctl_op_e'(ctl_op);
    assign wr_en         = ctl_req & supv & (op == CTL_WRITE);

    reloc_bounds #(.LO_RST(LO_RST), .HI_RST(HI_RST)) u_bounds (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (ctl_sel),
        .wr_data(ctl_wdata),
        .lo_q   (lo),
        .hi_q   (hi)
    );

    reloc_xlat u_xlat (
        .en   (mm_en),
        .laddr(xlat_laddr),
        .lo   (lo),
        .hi   (hi),
        .paddr(x_paddr),
        .abort(x_abort)
    );

    reloc_window_chk u_win (
        .addr   (ctl_wdata),
        .lo     (lo),
        .hi     (hi),
        .outside(outside)
    );

    always_comb begin
        rsp_d = '0;
        if (xlat_req) begin
            rsp_d.x.valid = 1'b1;
            rsp_d.x.abort = x_abort;
            rsp_d.x.addr  = x_paddr;
        end
        if (ctl_req) begin
            rsp_d.c.valid = 1'b1;
            if (!supv) begin
                rsp_d.c.priv = 1'b1;
            end else begin
                unique case (op)
                    CTL_READ:  rsp_d.c.data = ctl_sel ? hi : lo;
                    CTL_CHECK: rsp_d.c.ovf  = outside;
                    default:   rsp_d.c.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign xlat_rsp_valid = rsp_q.x.valid;
    assign xlat_abort     = rsp_q.x.abort;
    assign xlat_paddr     = rsp_q.x.addr;
    assign ctl_rsp_valid  = rsp_q.c.valid;
    assign ctl_priv_trap  = rsp_q.c.priv;
    assign ctl_ovf        = rsp_q.c.ovf;
    assign ctl_rdata      = rsp_q.c.data;
endmodule

// File: rtl/reloc_sva.sv
module reloc_sva #(
    parameter int unsigned STATUS_W   = 16,
    parameter int unsigned MMU_EN_BIT = 13,
    parameter int unsigned SUPV_BIT   = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] status_word,
    input logic                xlat_req,
    input logic [23:0]         xlat_laddr,
    input logic                xlat_rsp_valid,
    input logic [23:0]         xlat_paddr,
    input logic                xlat_abort,
    input logic                ctl_req,
    input logic [1:0]          ctl_op,
    input logic                ctl_sel,
    input logic [23:0]         ctl_wdata,
    input logic                ctl_rsp_valid,
    input logic [23:0]         ctl_rdata,
    input logic                ctl_priv_trap,
    input logic                ctl_ovf
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |=> xlat_rsp_valid);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_req |=> !xlat_rsp_valid);

    assert_abort_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_abort |-> (xlat_paddr == 24'd0));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !status_word[MMU_EN_BIT]) |=>
            (xlat_paddr == $past(xlat_laddr) && !xlat_abort));

    assert_user_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && !status_word[SUPV_BIT]) |=>
            (ctl_priv_trap && ctl_rdata == 24'd0 && !ctl_ovf));

    assert_write_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && status_word[SUPV_BIT] && ctl_op == 2'd1) ##1
        (ctl_req && status_word[SUPV_BIT] && ctl_op == 2'd0 && ctl_sel == $past(ctl_sel))
            |=> (ctl_rdata == $past(ctl_wdata, 2)));

    assert_rsvd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && status_word[SUPV_BIT] && ctl_op == 2'd3) |=>
            (ctl_rsp_valid && !ctl_priv_trap && !ctl_ovf && ctl_rdata == 24'd0));

    assert_abort_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_abort |-> xlat_rsp_valid);

    assert_priv_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_priv_trap |-> ctl_rsp_valid);
endmodule

bind addr_reloc_unit reloc_sva #(
    .STATUS_W  (STATUS_W),
    .MMU_EN_BIT(MMU_EN_BIT),
    .SUPV_BIT  (SUPV_BIT)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_word   (status_word),
    .xlat_req      (xlat_req),
    .xlat_laddr    (xlat_laddr),
    .xlat_rsp_valid(xlat_rsp_valid),
    .xlat_paddr    (xlat_paddr),
    .xlat_abort    (xlat_abort),
    .ctl_req       (ctl_req),
    .ctl_op        (ctl_op),
    .ctl_sel       (ctl_sel),
    .ctl_wdata     (ctl_wdata),
    .ctl_rsp_valid (ctl_rsp_valid),
    .ctl_rdata     (ctl_rdata),
    .ctl_priv_trap (ctl_priv_trap),
    .ctl_ovf       (ctl_ovf)
);

// File: tb/tb_addr_reloc_unit.sv
`timescale 1ns/1ps
module tb_addr_reloc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] status_word = '0;
    logic        xlat_req = 1'b0;
    logic [23:0] xlat_laddr = '0;
    logic        xlat_rsp_valid;
    logic [23:0] xlat_paddr;
    logic        xlat_abort;
    logic        ctl_req = 1'b0;
    logic [1:0]  ctl_op = '0;
    logic        ctl_sel = 1'b0;
    logic [23:0] ctl_wdata = '0;
    logic        ctl_rsp_valid;
    logic [23:0] ctl_rdata;
    logic        ctl_priv_trap;
    logic        ctl_ovf;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [23:0] lo_m = 24'h000000;
    logic [23:0] hi_m = 24'hFFFFFF;

    localparam logic [15:0] SW_SUP_EN  = 16'hA000;
    localparam logic [15:0] SW_SUP_OFF = 16'h8000;
    localparam logic [15:0] SW_USR_EN  = 16'h2000;

    always #2.5 clk = ~clk;

    addr_reloc_unit dut (
        .clk(clk), .rst_n(rst_n), .status_word(status_word),
        .xlat_req(xlat_req), .xlat_laddr(xlat_laddr),
        .xlat_rsp_valid(xlat_rsp_valid), .xlat_paddr(xlat_paddr), .xlat_abort(xlat_abort),
        .ctl_req(ctl_req), .ctl_op(ctl_op), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .ctl_rsp_valid(ctl_rsp_valid), .ctl_rdata(ctl_rdata),
        .ctl_priv_trap(ctl_priv_trap), .ctl_ovf(ctl_ovf)
    );

    task automatic chk(input string req, input string what, input string ctx,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s %s: actual %0h expected %0h", req, what, ctx, act, exp);
        end
    endtask

    function automatic logic [24:0] f_xlat(input logic en, input logic [23:0] la,
                                           input logic [23:0] lo, input logic [23:0] hi);
        logic [24:0] s;
        if (!en) return {1'b0, la};
        s = {1'b0, la} + {1'b0, lo};
        if (s[24] || s[23:0] > hi) return {1'b1, 24'd0};
        return {1'b0, s[23:0]};
    endfunction

    function automatic logic f_outside(input logic [23:0] a, input logic [23:0] lo,
                                       input logic [23:0] hi);
        return (a < lo) || (a > hi);
    endfunction

    task automatic step(input logic xv, input logic [23:0] la, input logic cv,
                        input logic [1:0] op, input logic sel, input logic [23:0] wd,
                        input logic [15:0] sw, input string ctx);
        logic [24:0] xr;
        logic        e_xv, e_ab, e_cv, e_pr, e_ov;
        logic [23:0] e_pa, e_rd;
        string       xt, ct;
        xr   = f_xlat(sw[13], la, lo_m, hi_m);
        e_xv = xv;
        e_ab = xv ? xr[24] : 1'b0;
        e_pa = xv ? xr[23:0] : 24'd0;
        xt   = !sw[13] ? "R4" : (xr[24] ? "R3" : "R2");
        e_cv = cv; e_pr = 1'b0; e_ov = 1'b0; e_rd = '0;
        ct   = "R6";
        if (cv) begin
            if (!sw[15]) begin
                e_pr = 1'b1; ct = "R5";
            end else begin
                case (op)
                    2'd0: e_rd = sel ? hi_m : lo_m;
                    2'd2: begin e_ov = f_outside(wd, lo_m, hi_m); ct = "R7"; end
                    2'd3: ct = "R9";
                    default: ct = "R6";
                endcase
            end
        end
        status_word = sw;
        xlat_req    = xv;
        xlat_laddr  = la;
        ctl_req     = cv;
        ctl_op      = op;
        ctl_sel     = sel;
        ctl_wdata   = wd;
        if (cv && sw[15] && op == 2'd1) begin
            if (sel) hi_m = wd;
            else     lo_m = wd;
        end
        @(negedge clk);
        chk("R2",     "xlat_rsp_valid", ctx, {31'd0, xlat_rsp_valid}, {31'd0, e_xv});
        chk(xt,       "xlat_paddr",     ctx, {8'd0, xlat_paddr},      {8'd0, e_pa});
        chk("R3/R10", "xlat_abort",     ctx, {31'd0, xlat_abort},     {31'd0, e_ab});
        chk(ct,       "ctl_rsp_valid",  ctx, {31'd0, ctl_rsp_valid},  {31'd0, e_cv});
        chk(ct,       "ctl_rdata",      ctx, {8'd0, ctl_rdata},       {8'd0, e_rd});
        chk("R5/R10", "ctl_priv_trap",  ctx, {31'd0, ctl_priv_trap},  {31'd0, e_pr});
        chk(ct,       "ctl_ovf",        ctx, {31'd0, ctl_ovf},        {31'd0, e_ov});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all R): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "xlat_rsp_valid in reset", "", {31'd0, xlat_rsp_valid}, 32'd0);
        chk("R1", "ctl_rsp_valid in reset",  "", {31'd0, ctl_rsp_valid},  32'd0);
        chk("R1", "traps in reset", "", {30'd0, xlat_abort, ctl_priv_trap}, 32'd0);
        rst_n = 1'b1;
        // R1: reset bound values
        step(0, 0, 1, 2'd0, 0, 0, SW_SUP_EN, "R1 read low");
        step(0, 0, 1, 2'd0, 1, 0, SW_SUP_EN, "R1 read high");
        step(1, 24'hFFFFFF, 0, 0, 0, 0, SW_SUP_EN, "R1 top passes");
        // R6 writes, R2/R3 boundaries
        step(0, 0, 1, 2'd1, 0, 24'h001000, SW_SUP_EN, "R6 write low");
        step(0, 0, 1, 2'd1, 1, 24'h00FFFF, SW_SUP_EN, "R6 write high");
        step(0, 0, 1, 2'd0, 1, 0, SW_SUP_EN, "R6 read high");
        step(1, 24'h00EFFF, 0, 0, 0, 0, SW_SUP_EN, "R2 equal high ok");
        step(1, 24'h00F000, 0, 0, 0, 0, SW_SUP_EN, "R3 one above high");
        step(1, 24'h123456, 0, 0, 0, 0, SW_SUP_OFF, "R4 bypass");
        // carry case
        step(0, 0, 1, 2'd1, 0, 24'hFFFF00, SW_SUP_EN, "R6 write low high");
        step(0, 0, 1, 2'd1, 1, 24'hFFFFFF, SW_SUP_EN, "R6 write high top");
        step(1, 24'h000200, 0, 0, 0, 0, SW_SUP_EN, "R3 carry out");
        step(1, 24'h0000FF, 0, 0, 0, 0, SW_SUP_EN, "R2 sum at top");
        // R5 user mode
        step(0, 0, 1, 2'd1, 0, 24'h000000, SW_USR_EN, "R5 user write");
        step(0, 0, 1, 2'd0, 0, 0, SW_SUP_EN, "R5 low unchanged");
        step(0, 0, 1, 2'd2, 0, 24'h000000, SW_USR_EN, "R5 user validate");
        step(0, 0, 1, 2'd0, 1, 0, SW_USR_EN, "R5 user read");
        // R7 validate with translation off
        step(0, 0, 1, 2'd2, 0, 24'hFFFF00, SW_SUP_OFF, "R7 at low");
        step(0, 0, 1, 2'd2, 0, 24'hFFFEFF, SW_SUP_OFF, "R7 below low");
        // R9 reserved op
        step(0, 0, 1, 2'd3, 1, 24'h000001, SW_SUP_EN, "R9 reserved");
        step(0, 0, 1, 2'd0, 1, 0, SW_SUP_EN, "R9 high unchanged");
        // R8 same cycle write and translate
        step(1, 24'h000020, 1, 2'd1, 1, 24'hFFFF10, SW_SUP_EN, "R8 old high used");
        step(1, 24'h000020, 0, 0, 0, 0, SW_SUP_EN, "R8 new high used");
        step(0, 0, 1, 2'd2, 0, 24'hFFFF11, SW_SUP_EN, "R7 above high");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] sw;
            logic [23:0] la, wd;
            logic [1:0]  op;
            sw = 16'($urandom);
            sw[15] = ($urandom % 5) != 0;
            sw[13] = ($urandom % 10) < 7;
            la = ($urandom % 2) ? 24'($urandom) : 24'(hi_m - lo_m + 24'($urandom % 5) - 24'd2);
            op = 2'($urandom);
            case ($urandom % 3)
                0: wd = 24'($urandom);
                1: wd = 24'($urandom % 24'h400000);
                default: wd = ($urandom % 2) ? lo_m - 24'($urandom % 2) : hi_m + 24'($urandom % 2);
            endcase
            step(1'($urandom), la, 1'($urandom), op, 1'($urandom), wd, sw, "random");
        end
        step(0, 0, 0, 0, 0, 0, SW_SUP_EN, "idle");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule